// File: doc/BRIEF.md
# Command-Queued I2C Bus Master

This block drives an I2C bus as its only master under control of a small register file. Software loads an outgoing byte, then writes one or more command bits at once (start, transmit, receive, receive-with-NACK, stop). The engine queues them and carries them out in a fixed order: start first, then the transmit byte, then the receive byte, then stop. Each command bit clears itself when its bus phase ends. The result of every phase lands in a sticky status bit that software clears by writing a one to it. The interrupt line is the OR of the status bits that are both set and enabled.

Bit timing comes from an external `tick` strobe, one pulse for each quarter of an SCL period. Ticks must be at least four clock cycles apart, so that the two-flop input synchronizers settle between quarters. SCL and SDA are open-drain: a high `*_oe` pulls the line low, and a low `*_oe` releases it. A slave may stretch SCL, and a stretch that outlasts `TMO_TICKS` quarter ticks aborts the queue. Losing arbitration on a transmitted one, or asking for a data phase without owning the bus, also aborts the queue and releases both lines.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the pending command bits and all status bits read zero, both open-drain enables are low and `irq` is low.
- R2: Command bits sit in register 0: start = bit 0, transmit = bit 1, receive = bit 3, receive-with-NACK = bit 4, stop = bit 5. Start with transmit puts a START on the bus, then shifts out byte-buffer bits 7:0 MSB first. An ACK (SDA low in the ninth clock) sets status bit 0, and a NAK sets status bit 1.
- R3: Start, transmit and receive written together send the address and then take one data byte with no further writes. The received byte reads back in bits 15:8 of register 1 and sets status bit 2. The master drives ACK on the ninth clock, or NACK when bit 4 was set.
- R4: Queued bits run as start, transmit, receive, stop, whatever their order in the write. Each pending bit reads back in register 0 bits 5:0 until its phase ends, and then clears on its own.
- R5: The stop command produces a STOP condition, releases both lines and sets status bit 4.
- R6: Status register 3 is write-one-to-clear. Zero bits in the write leave their status bits unchanged, and a set status bit stays set until it is cleared.
- R7: The enable register 2 uses the status layout (ACK 0, NAK 1, receive 2, arbitration 3, stop 4, abnormal 5, SCL timeout 6). `irq` is high exactly when an enabled status bit is set.
- R8: Register 0 bit 16 shows bus busy, set by a START seen on the lines and cleared by a STOP. Bit 17 shows the synchronized SDA level and bit 18 the synchronized SCL level.
- R9: If the engine releases SDA for a one in a transmitted bit but samples it low, status bit 3 sets, all pending bits clear and both lines are released.
- R10: If SCL stays low for `TMO_TICKS` quarter ticks after the engine releases it, status bit 6 sets, all pending bits clear and both lines are released.
- R11: A transmit or receive requested while the engine does not hold the bus sets status bit 5 and clears all pending bits.
- R12: While the engine neither holds the bus nor runs a phase, both open-drain enables stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command/state, 1 byte buffer, 2 enable, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle by the assertions. Pending bits never appear without a register write. An abort empties the queue and frees both lines. The lines stay released while the bus is not held. Busy follows the START and STOP conditions seen on the lines. Status bits stay set unless cleared and do clear on a one write. Only the bench scenarios, which use a modelled slave, random addresses, data and acknowledge choices, and directed faults (a jammed SDA, a held SCL, a data phase without a start), can show the rest: the bit order on the wire, the ACK or NACK the master drives, the received byte and the phase order.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int CMD_W    = 6;
  localparam int CB_START = 0;
  localparam int CB_TX    = 1;
  localparam int CB_RX    = 3;
  localparam int CB_LAST  = 4;
  localparam int CB_STOP  = 5;
  localparam logic [CMD_W-1:0] CMD_MASK = 6'b111011;

  localparam int EV_W    = 7;
  localparam int EV_ACK  = 0;
  localparam int EV_NAK  = 1;
  localparam int EV_RXD  = 2;
  localparam int EV_ARB  = 3;
  localparam int EV_STOP = 4;
  localparam int EV_ABN  = 5;
  localparam int EV_TMO  = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BYTE, PH_STOP} phase_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic busy
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p, busy_q, busy_d;
  logic       start_det, stop_det;

  assign scl_s = scl_sync[1];
  assign sda_s = sda_sync[1];
  assign busy  = busy_q;

  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_comb begin
    busy_d = busy_q;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      busy_q   <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
      busy_q   <= busy_d;
    end
  end

  p_busy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  p_busy_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs #(
  parameter int EV_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  input  logic            sts_we,
  input  logic            en_we,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] sts,
  output logic [EV_W-1:0] en,
  output logic            irq
);
  logic [EV_W-1:0] sts_q, sts_d, en_q, en_d;

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    if (sts_we) sts_d = sts_d & ~wdata;
    sts_d = sts_d | ev;
    if (en_we) en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts = sts_q;
  assign en  = en_q;
  assign irq = |(sts_q & en_q);

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && ev == '0) |=> ((sts & $past(wdata)) == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_we |=> ((sts & $past(sts)) == $past(sts)));
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int TMO_TICKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic [7:0]       tx_byte,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic [CMD_W-1:0] pend,
  output logic [7:0]       rx_byte,
  output logic [EV_W-1:0]  ev,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             owned
);
  localparam int TW = $clog2(TMO_TICKS + 1);

  phase_e           st_q, st_d;
  logic [1:0]       q_q, q_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, rxb_q, rxb_d;
  logic             rx_q, rx_d, last_q, last_d, nak_q, nak_d;
  logic [TW-1:0]    tmo_q, tmo_d;
  logic [CMD_W-1:0] pend_q, pend_d;
  logic             scl_q, scl_d, sda_q, sda_d, own_q, own_d;
  logic             err;

  always_comb begin
    st_d = st_q;  q_d = q_q;  bit_d = bit_q;  sh_d = sh_q;  rxb_d = rxb_q;
    rx_d = rx_q;  last_d = last_q;  nak_d = nak_q;  tmo_d = tmo_q;
    scl_d = scl_q;  sda_d = sda_q;  own_d = own_q;
    ev  = '0;
    err = 1'b0;
    pend_d = pend_q | (cmd_we ? (cmd_wdata & CMD_MASK) : '0);
    if (tick) begin
      if (st_q == PH_IDLE) begin
        q_d   = 2'd0;
        tmo_d = '0;
        if (pend_q[CB_START]) begin
          st_d = PH_START;
        end else if (pend_q[CB_TX] | pend_q[CB_RX] | pend_q[CB_LAST]) begin
          if (!own_q) begin
            ev[EV_ABN] = 1'b1;
            err        = 1'b1;
          end else begin
            st_d   = PH_BYTE;
            bit_d  = 4'd0;
            rx_d   = ~pend_q[CB_TX];
            last_d = pend_q[CB_LAST];
            sh_d   = pend_q[CB_TX] ? tx_byte : 8'h00;
          end
        end else if (pend_q[CB_STOP]) begin
          st_d = PH_STOP;
        end
      end else if (q_q == 2'd2 && !scl_s) begin
        // slave stretching SCL: count quarter ticks
        tmo_d = tmo_q + 1'b1;
        if (tmo_q == TW'(TMO_TICKS - 1)) begin
          ev[EV_TMO] = 1'b1;
          err        = 1'b1;
        end
      end else begin
        q_d   = q_q + 1'b1;
        tmo_d = '0;
        case (st_q)
          PH_START: begin
            case (q_q)
              2'd0: sda_d = 1'b0;
              2'd1: scl_d = 1'b0;
              2'd2: sda_d = 1'b1;
              default: begin
                scl_d = 1'b1;
                own_d = 1'b1;
                pend_d[CB_START] = 1'b0;
                st_d = PH_IDLE;
              end
            endcase
          end
          PH_STOP: begin
            case (q_q)
              2'd0: sda_d = 1'b1;
              2'd1: scl_d = 1'b0;
              2'd2: sda_d = 1'b0;
              default: begin
                own_d = 1'b0;
                pend_d[CB_STOP] = 1'b0;
                ev[EV_STOP] = 1'b1;
                st_d = PH_IDLE;
              end
            endcase
          end
          default: begin
            case (q_q)
              2'd0: sda_d = (bit_q == 4'd8) ? (rx_q & ~last_q) : (~rx_q & ~sh_q[7]);
              2'd1: scl_d = 1'b0;
              2'd2: begin
                if (bit_q == 4'd8) begin
                  nak_d = sda_s;
                end else if (rx_q) begin
                  sh_d = {sh_q[6:0], sda_s};
                end else begin
                  if (sh_q[7] && !sda_s) begin
                    ev[EV_ARB] = 1'b1;
                    err        = 1'b1;
                  end
                  sh_d = {sh_q[6:0], 1'b0};
                end
              end
              default: begin
                scl_d = 1'b1;
                if (bit_q == 4'd8) begin
                  st_d = PH_IDLE;
                  if (rx_q) begin
                    rxb_d = sh_q;
                    ev[EV_RXD] = 1'b1;
                    pend_d[CB_RX]   = 1'b0;
                    pend_d[CB_LAST] = 1'b0;
                  end else begin
                    ev[nak_q ? EV_NAK : EV_ACK] = 1'b1;
                    pend_d[CB_TX] = 1'b0;
                  end
                end else begin
                  bit_d = bit_q + 1'b1;
                end
              end
            endcase
          end
        endcase
      end
    end
    if (err) begin
      st_d = PH_IDLE;  pend_d = '0;  q_d = 2'd0;  tmo_d = '0;
      scl_d = 1'b0;  sda_d = 1'b0;  own_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;  q_q <= 2'd0;  bit_q <= 4'd0;  sh_q <= 8'h00;
      rxb_q <= 8'h00;  rx_q <= 1'b0;  last_q <= 1'b0;  nak_q <= 1'b0;
      tmo_q <= '0;  pend_q <= '0;  scl_q <= 1'b0;  sda_q <= 1'b0;  own_q <= 1'b0;
    end else begin
      st_q <= st_d;  q_q <= q_d;  bit_q <= bit_d;  sh_q <= sh_d;
      rxb_q <= rxb_d;  rx_q <= rx_d;  last_q <= last_d;  nak_q <= nak_d;
      tmo_q <= tmo_d;  pend_q <= pend_d;  scl_q <= scl_d;  sda_q <= sda_d;  own_q <= own_d;
    end
  end

  assign pend    = pend_q;
  assign rx_byte = rxb_q;
  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;
  assign owned   = own_q;

  p_selfclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> ((pend & ~$past(pend)) == '0));
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (pend == '0 && !scl_oe && !sda_oe));
  p_tmo_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_TMO] |=> !owned);
  p_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && !owned) |-> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int TMO_TICKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  localparam logic [1:0] A_CMD = 2'd0;
  localparam logic [1:0] A_BUF = 2'd1;
  localparam logic [1:0] A_EN  = 2'd2;
  localparam logic [1:0] A_STS = 2'd3;

  logic             scl_s, sda_s, busy, owned;
  logic [CMD_W-1:0] pend;
  logic [7:0]       rx_byte, tx_q, tx_d;
  logic [EV_W-1:0]  ev, sts, en;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[31:8];

  always_comb begin
    tx_d = tx_q;
    if (reg_we && reg_addr == A_BUF) tx_d = reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 8'h00;
    else        tx_q <= tx_d;
  end

  i2c_line_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .busy(busy)
  );

  i2c_cmd_engine #(.TMO_TICKS(TMO_TICKS)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_we(reg_we && reg_addr == A_CMD), .cmd_wdata(reg_wdata[CMD_W-1:0]),
    .tx_byte(tx_q), .scl_s(scl_s), .sda_s(sda_s),
    .pend(pend), .rx_byte(rx_byte), .ev(ev),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .owned(owned)
  );

  i2c_irq_regs #(.EV_W(EV_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .sts_we(reg_we && reg_addr == A_STS), .en_we(reg_we && reg_addr == A_EN),
    .wdata(reg_wdata[EV_W-1:0]), .sts(sts), .en(en), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {13'b0, scl_s, sda_s, busy, 10'b0, pend};
      A_BUF:   reg_rdata = {16'b0, rx_byte, tx_q};
      A_EN:    reg_rdata = {{(32-EV_W){1'b0}}, en};
      default: reg_rdata = {{(32-EV_W){1'b0}}, sts};
    endcase
  end

  p_own_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned) |-> !scl_s || busy || !sda_s);
endmodule

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
  logic clk, rst_n, tick, reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic scl_hold, jam, sl_drive;
  wire  scl_bus = ~(scl_oe | scl_hold);
  wire  sda_bus = ~(sda_oe | sl_drive | jam);

  int checks, errors;

  i2c_cmd_master #(.TMO_TICKS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  initial begin clk = 1'b0; forever #4 clk = ~clk; end

  initial begin
    tick = 1'b0;
    forever begin
      repeat (4) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // modelled slave
  logic       active, fresh, rd, nacked, ack_addr, ack_data, mack;
  int         bitn, bidx;
  logic [7:0] shreg, got, rd_byte;

  always @(negedge sda_bus) if (scl_bus) begin
    active = 1; fresh = 1; bitn = 0; bidx = 0; rd = 0; nacked = 0; sl_drive = 0;
  end
  always @(posedge sda_bus) if (scl_bus) begin active = 0; sl_drive = 0; end
  always @(posedge scl_bus) if (active) begin
    if (bitn < 8) shreg = {shreg[6:0], sda_bus};
    else if (rd && bidx > 0) begin mack = sda_bus; if (sda_bus) nacked = 1; end
  end
  always @(negedge scl_bus) if (active) begin
    if (fresh) fresh = 0;
    else if (bitn == 8) begin bitn = 0; bidx++; end
    else bitn++;
    sl_drive = 0;
    if (bitn == 8) begin
      if (bidx == 0) begin
        got = shreg;
        if (ack_addr) begin sl_drive = 1; rd = shreg[0]; end else active = 0;
      end else if (!rd) begin
        got = shreg; sl_drive = ack_data;
      end
    end else if (rd && bidx > 0 && !nacked) sl_drive = ~rd_byte[7-bitn];
  end

  function automatic bit f_irq(logic [6:0] s, logic [6:0] e);
    return |(s & e);
  endfunction
  function automatic logic [6:0] f_tx_sts(logic ack);
    return ack ? 7'h01 : 7'h02;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  logic order_bad;
  task automatic wait_done();
    logic [31:0] v, s;
    for (int i = 0; i < 8000; i++) begin
      rd_reg(2'd3, s);
      if (s[4] && !s[2] && s[0]) order_bad = 1;
      rd_reg(2'd0, v);
      if (v[5:0] == 6'd0) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [6:0]  a;
    logic [7:0]  d;
    void'($urandom(32'd1234));
    checks = 0; errors = 0; order_bad = 0;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    scl_hold = 0; jam = 0; sl_drive = 0; active = 0; fresh = 0;
    bitn = 0; bidx = 0; rd = 0; nacked = 0; mack = 0;
    ack_addr = 1; ack_data = 1; rd_byte = 8'h00; shreg = 0; got = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    rd_reg(2'd0, v); chk("R1 R8 cmd/state after reset", v, 32'h0006_0000);
    rd_reg(2'd3, v); chk("R1 status after reset", v, 0);
    chk("R1 lines released", {30'b0, scl_oe, sda_oe}, 0);
    chk("R1 irq low", {31'b0, irq}, 0);

    wr(2'd2, 32'h7F);
    // R2 R5 random write transfers
    for (int n = 0; n < 6; n++) begin
      a = 7'($urandom); d = 8'($urandom);
      ack_addr = 1'($urandom); ack_data = 1'($urandom);
      if (n == 0) ack_addr = 1;
      wr(2'd1, {24'b0, a, 1'b0});
      wr(2'd0, 32'h03);
      wait_done();
      rd_reg(2'd3, v); chk("R2 address result", v, {25'b0, f_tx_sts(ack_addr)});
      chk("R2 address on wire", {24'b0, got}, {24'b0, a, 1'b0});
      chk("R7 irq with all enabled", {31'b0, irq}, {31'b0, f_irq(v[6:0], 7'h7F)});
      rd_reg(2'd0, v); chk("R8 busy after start", {31'b0, v[16]}, 1);
      wr(2'd3, 32'h7F);
      rd_reg(2'd3, v); chk("R6 clear all", v, 0);
      if (ack_addr) begin
        wr(2'd1, {24'b0, d});
        wr(2'd0, 32'h02);
        wait_done();
        rd_reg(2'd3, v); chk("R2 data result", v, {25'b0, f_tx_sts(ack_data)});
        chk("R2 data on wire", {24'b0, got}, {24'b0, d});
        wr(2'd3, 32'h7F);
      end
      wr(2'd0, 32'h20);
      wait_done();
      rd_reg(2'd3, v); chk("R5 stop status", v, 32'h10);
      rd_reg(2'd0, v); chk("R8 idle after stop", v, 32'h0006_0000);
      chk("R12 released after stop", {30'b0, scl_oe, sda_oe}, 0);
      wr(2'd3, 32'h7F);
    end

    // R3 combined address + read with ACK, then read with NACK
    ack_addr = 1; a = 7'($urandom); rd_byte = 8'($urandom);
    wr(2'd1, {24'b0, a, 1'b1});
    wr(2'd0, 32'h0B);
    wait_done();
    rd_reg(2'd3, v); chk("R3 combined status", v, 32'h05);
    rd_reg(2'd1, v); chk("R3 received byte", {24'b0, v[15:8]}, {24'b0, rd_byte});
    chk("R3 master ACK", {31'b0, mack}, 0);
    wr(2'd3, 32'h7F);
    wr(2'd0, 32'h18);
    wait_done();
    rd_reg(2'd3, v); chk("R3 last-byte status", v, 32'h04);
    rd_reg(2'd1, v); chk("R3 second byte", {24'b0, v[15:8]}, {24'b0, rd_byte});
    chk("R3 master NACK", {31'b0, mack}, 1);
    wr(2'd3, 32'h7F);
    wr(2'd0, 32'h20);
    wait_done();
    wr(2'd3, 32'h7F);

    // R4 all phases in one write
    rd_byte = 8'hC3; order_bad = 0;
    wr(2'd1, 32'h0000_00A5);
    wr(2'd0, 32'h3B);
    rd_reg(2'd0, v); chk("R4 pending readback", {26'b0, v[5:0]}, 32'h3B);
    wait_done();
    rd_reg(2'd3, v); chk("R4 all phase results", v, 32'h15);
    chk("R4 stop not before receive", {31'b0, order_bad}, 0);
    rd_reg(2'd1, v); chk("R4 byte read", {24'b0, v[15:8]}, 32'hC3);
    rd_reg(2'd0, v); chk("R4 R8 pending cleared, idle", v, 32'h0006_0000);

    // R6 partial clear, R7 masking
    wr(2'd3, 32'h04);
    rd_reg(2'd3, v); chk("R6 partial clear", v, 32'h11);
    wr(2'd3, 32'h00);
    rd_reg(2'd3, v); chk("R6 zero write no effect", v, 32'h11);
    wr(2'd2, 32'h10);
    chk("R7 enabled bit set", {31'b0, irq}, {31'b0, f_irq(7'h11, 7'h10)});
    wr(2'd2, 32'h04);
    chk("R7 masked", {31'b0, irq}, {31'b0, f_irq(7'h11, 7'h04)});
    wr(2'd2, 32'h7F);
    wr(2'd3, 32'h7F);

    // R11 data phase without bus ownership
    wr(2'd0, 32'h02);
    wait_done();
    rd_reg(2'd3, v); chk("R11 abnormal status", v, 32'h20);
    chk("R11 lines released", {30'b0, scl_oe, sda_oe}, 0);
    wr(2'd3, 32'h7F);

    // R9 arbitration loss on a transmitted one
    wr(2'd1, 32'h0000_00A0);
    wr(2'd0, 32'h23);
    @(negedge sda_bus);
    jam = 1;
    wait_done();
    rd_reg(2'd3, v); chk("R9 arbitration status", v, 32'h08);
    rd_reg(2'd0, v); chk("R9 queue flushed", {26'b0, v[5:0]}, 0);
    chk("R9 lines released", {30'b0, scl_oe, sda_oe}, 0);
    jam = 0;
    repeat (6) @(negedge clk);
    rd_reg(2'd0, v); chk("R8 busy cleared by stop", {31'b0, v[16]}, 0);
    wr(2'd3, 32'h7F);

    // R10 SCL held low
    scl_hold = 1;
    repeat (4) @(negedge clk);
    rd_reg(2'd0, v); chk("R8 scl level low", {31'b0, v[18]}, 0);
    wr(2'd0, 32'h21);
    wait_done();
    rd_reg(2'd3, v); chk("R10 timeout status", v, 32'h40);
    rd_reg(2'd0, v); chk("R10 queue flushed", {26'b0, v[5:0]}, 0);
    chk("R10 lines released", {30'b0, scl_oe, sda_oe}, 0);
    scl_hold = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule